// File: doc/BRIEF.md
# Accumulating Halfword Multiplier

This block holds a 64-bit signed accumulator and updates it with signed 16x16 products taken from either the upper or the lower halfword of two 32-bit operands. The product can replace the accumulator or be added into it. A rounding operation scales the accumulator by a small left shift, adds a bias of one half of the upper-word LSB, and clamps the result to a 48-bit signed window whose low 32 bits are zero. Slice reads and half-word loads let the surrounding core move accumulator contents to and from 32-bit registers.

Each clock cycle carries one operation. State changes take effect at the clock edge. A read places its slice on the result port at that same edge, and the port holds that value until the next read.

Top module: `acc_mac_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator and `rd_data_o` both become zero.
- R2: Op code 1 forms the signed product of `src_a_i[31:16]` and `src_b_i[31:16]`. It shifts the product left by 16, sign-extends it to 64 bits and replaces the accumulator with the result.
- R3: Op code 2 does the same as R2 but uses bits 15:0 of both operands.
- R4: Op codes 3 (upper halfwords) and 4 (lower halfwords) add the shifted, sign-extended product to the accumulator. The sum wraps modulo 2^64.
- R5: Op code 5 rounds the accumulator in three steps. It shifts left by `shamt_i`, where a value of 2 means 2 and every other value means 1. It then adds 0x80000000. If no clamping occurs, bits 31:0 of the result are cleared.
- R6: During op 5, a rounded value greater than 0x00007FFF00000000 (signed) is replaced by 0x00007FFF00000000.
- R7: During op 5, a rounded value less than 0xFFFF800000000000 (signed) is replaced by 0xFFFF800000000000.
- R8: Op codes 6, 7 and 8 load `rd_data_o` at the clock edge with accumulator bits 63:32, 47:16 and 31:0 respectively. Every other op leaves `rd_data_o` unchanged.
- R9: Op code 9 loads accumulator bits 63:32 from `src_a_i`, and op code 10 loads bits 31:0 from `src_a_i`. The other half is kept.
- R10: Op code 0, the read ops and unused codes 11 to 15 leave the accumulator unchanged, whatever the operand values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 4 | Operation code |
| src_a_i | input | 32 | First operand; the data for half loads |
| src_b_i | input | 32 | Second operand |
| shamt_i | input | 2 | Rounding shift amount |
| rd_data_o | output | 32 | Registered slice-read result |

## Verification
The accumulator is visible only through slice reads. A corrupted accumulator therefore shows up on `rd_data_o` one edge after the next read op. The bench issues reads right after each update, so a wrong product sign, a wrong halfword select, a missing carry across the 32-bit boundary, or a bad clamp boundary appears within one or two cycles. A result register that changes on a non-read op shows up on the very next cycle, because the port is compared with the model on every clock.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
    localparam int REG_W  = 32;
    localparam int HALF_W = REG_W / 2;
    localparam int ACC_W  = 64;
    localparam int SH_W   = 2;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_MULHI  = 4'd1,
        OP_MULLO  = 4'd2,
        OP_MACHI  = 4'd3,
        OP_MACLO  = 4'd4,
        OP_ROUND  = 4'd5,
        OP_RDHI   = 4'd6,
        OP_RDMID  = 4'd7,
        OP_RDLO   = 4'd8,
        OP_WRHI   = 4'd9,
        OP_WRLO   = 4'd10
    } mac_op_e;

    typedef struct packed {
        logic upper;
        logic accumulate;
        logic active;
    } mul_ctl_t;

    localparam logic [ACC_W-1:0] SAT_POS  = 64'h0000_7FFF_0000_0000;
    localparam logic [ACC_W-1:0] SAT_NEG  = 64'hFFFF_8000_0000_0000;
    localparam logic [ACC_W-1:0] RND_BIAS = 64'h0000_0000_8000_0000;

    function automatic logic op_is_read(input logic [3:0] op);
        return (op == OP_RDHI) || (op == OP_RDMID) || (op == OP_RDLO);
    endfunction

    function automatic mul_ctl_t decode_mul(input logic [3:0] op);
        mul_ctl_t c;
        c.active     = (op == OP_MULHI) || (op == OP_MULLO) ||
                       (op == OP_MACHI) || (op == OP_MACLO);
        c.upper      = (op == OP_MULHI) || (op == OP_MACHI);
        c.accumulate = (op == OP_MACHI) || (op == OP_MACLO);
        return c;
    endfunction
endpackage

// File: rtl/mac_mult.sv
`timescale 1ns/1ps
module mac_mult #(
    parameter int REG_W = 32,
    parameter int ACC_W = 64
) (
    input  logic [REG_W-1:0] a_i,
    input  logic [REG_W-1:0] b_i,
    input  logic             upper_i,
    output logic [ACC_W-1:0] term_o
);
    localparam int HW  = REG_W / 2;
    localparam int EXT = ACC_W - REG_W - HW;

    logic signed [HW-1:0]    ha;
    logic signed [HW-1:0]    hb;
    logic signed [REG_W-1:0] prod;

    always_comb begin
        ha     = upper_i ? a_i[REG_W-1:HW] : a_i[HW-1:0];
        hb     = upper_i ? b_i[REG_W-1:HW] : b_i[HW-1:0];
        prod   = ha * hb;
        term_o = {{EXT{prod[REG_W-1]}}, prod, {HW{1'b0}}};
    end
endmodule

// File: rtl/mac_round.sv
`timescale 1ns/1ps
module mac_round
    import mac_pkg::*;
#(
    parameter int SHW = 2
) (
    input  logic [ACC_W-1:0] acc_i,
    input  logic [SHW-1:0]   shamt_i,
    output logic [ACC_W-1:0] rnd_o
);
    logic [ACC_W-1:0] shifted;
    logic [ACC_W-1:0] biased;

    always_comb begin
        shifted = (shamt_i == SHW'(2)) ? (acc_i << 2) : (acc_i << 1);
        biased  = shifted + RND_BIAS;
        if ($signed(biased) > $signed(SAT_POS))
            rnd_o = SAT_POS;
        else if ($signed(biased) < $signed(SAT_NEG))
            rnd_o = SAT_NEG;
        else
            rnd_o = {biased[ACC_W-1:REG_W], {REG_W{1'b0}}};
    end
endmodule

// File: rtl/mac_slice.sv
`timescale 1ns/1ps
module mac_slice
    import mac_pkg::*;
(
    input  logic [ACC_W-1:0] acc_i,
    input  logic [3:0]       op_i,
    output logic [REG_W-1:0] slice_o
);
    always_comb begin
        case (op_i)
            OP_RDHI:  slice_o = acc_i[ACC_W-1:REG_W];
            OP_RDMID: slice_o = acc_i[REG_W+HALF_W-1:HALF_W];
            default:  slice_o = acc_i[REG_W-1:0];
        endcase
    end
endmodule

// File: rtl/acc_mac_unit.sv
`timescale 1ns/1ps
module acc_mac_unit
    import mac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [3:0]       op_i,
    input  logic [31:0]      src_a_i,
    input  logic [31:0]      src_b_i,
    input  logic [1:0]       shamt_i,
    output logic [31:0]      rd_data_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] term;
    logic [ACC_W-1:0] rounded;
    logic [REG_W-1:0] slice;
    mul_ctl_t         mctl;

    assign mctl = decode_mul(op_i);

    mac_mult #(.REG_W(REG_W), .ACC_W(ACC_W)) u_mult (
        .a_i(src_a_i), .b_i(src_b_i), .upper_i(mctl.upper), .term_o(term)
    );

    mac_round #(.SHW(SH_W)) u_round (
        .acc_i(acc_q), .shamt_i(shamt_i), .rnd_o(rounded)
    );

    mac_slice u_slice (
        .acc_i(acc_q), .op_i(op_i), .slice_o(slice)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q     <= '0;
            rd_data_o <= '0;
        end else begin
            if (mctl.active)
                acc_q <= mctl.accumulate ? (acc_q + term) : term;
            else if (op_i == OP_ROUND)
                acc_q <= rounded;
            else if (op_i == OP_WRHI)
                acc_q[ACC_W-1:REG_W] <= src_a_i;
            else if (op_i == OP_WRLO)
                acc_q[REG_W-1:0] <= src_a_i;
            if (op_is_read(op_i))
                rd_data_o <= slice;
        end
    end
endmodule

// File: rtl/mac_checker.sv
`timescale 1ns/1ps
module mac_checker
    import mac_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [3:0]       op_i,
    input logic [31:0]      src_a_i,
    input logic [31:0]      rd_data_o,
    input logic [ACC_W-1:0] acc
);
    logic acc_hold_op;
    assign acc_hold_op = (op_i == OP_NOP) || op_is_read(op_i) || (op_i > OP_WRLO);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (acc == '0 && rd_data_o == '0));

    assert_round_low_zero_R5: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_ROUND |=> acc[31:0] == '0);

    assert_round_upper_bound_R6: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_ROUND |=> $signed(acc) <= $signed(SAT_POS));

    assert_round_lower_bound_R7: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_ROUND |=> $signed(acc) >= $signed(SAT_NEG));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !op_is_read(op_i) |=> $stable(rd_data_o));

    assert_write_low_R9: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_WRLO |=> (acc[31:0] == $past(src_a_i) && $stable(acc[63:32])));

    assert_write_high_R9: assert property (@(posedge clk) disable iff (rst)
        op_i == OP_WRHI |=> (acc[63:32] == $past(src_a_i) && $stable(acc[31:0])));

    assert_acc_hold_R10: assert property (@(posedge clk) disable iff (rst)
        acc_hold_op |=> $stable(acc));
endmodule

bind acc_mac_unit mac_checker u_mac_checker (
    .clk(clk), .rst(rst), .op_i(op_i), .src_a_i(src_a_i),
    .rd_data_o(rd_data_o), .acc(acc_q)
);

// File: tb/acc_mac_unit_test.sv
`timescale 1ns/1ps
module acc_mac_unit_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  op_i;
    logic [31:0] src_a_i;
    logic [31:0] src_b_i;
    logic [1:0]  shamt_i;
    logic [31:0] rd_data_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    longint      m_acc;
    logic [31:0] m_rd;

    always #2 clk = ~clk;

    acc_mac_unit uut (
        .clk(clk), .rst(rst), .op_i(op_i), .src_a_i(src_a_i),
        .src_b_i(src_b_i), .shamt_i(shamt_i), .rd_data_o(rd_data_o)
    );

    function automatic longint prod_term(input logic [15:0] x, input logic [15:0] y);
        longint p;
        p = longint'($signed(x)) * longint'($signed(y));
        return p * 65536;
    endfunction

    function automatic longint round_ref(input longint v, input logic [1:0] sh);
        longint s;
        longint hi_lim;
        longint lo_lim;
        hi_lim = 64'h0000_7FFF_0000_0000;
        lo_lim = 64'hFFFF_8000_0000_0000;
        s = (sh == 2'd2) ? (v * 4) : (v * 2);
        s = s + 64'h8000_0000;
        if (s > hi_lim) return hi_lim;
        if (s < lo_lim) return lo_lim;
        return s & 64'hFFFF_FFFF_0000_0000;
    endfunction

    task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s rd_data_o=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                        input logic [1:0] sh, input string tag);
        longint nxt;
        logic [63:0] u;
        op_i = op; src_a_i = a; src_b_i = b; shamt_i = sh;
        nxt = m_acc;
        u = m_acc;
        case (op)
            4'd1: nxt = prod_term(a[31:16], b[31:16]);
            4'd2: nxt = prod_term(a[15:0], b[15:0]);
            4'd3: nxt = m_acc + prod_term(a[31:16], b[31:16]);
            4'd4: nxt = m_acc + prod_term(a[15:0], b[15:0]);
            4'd5: nxt = round_ref(m_acc, sh);
            4'd6: m_rd = u[63:32];
            4'd7: m_rd = u[47:16];
            4'd8: m_rd = u[31:0];
            4'd9: begin u[63:32] = a; nxt = u; end
            4'd10: begin u[31:0] = a; nxt = u; end
            default: ;
        endcase
        @(posedge clk);
        m_acc = nxt;
        @(negedge clk);
        check(rd_data_o, m_rd, tag);
    endtask

    task automatic read_all(input string tag);
        step(4'd6, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'd3, tag);
        step(4'd7, 32'h0, 32'h0, 2'd0, tag);
        step(4'd8, 32'h0, 32'h0, 2'd0, tag);
    endtask

    task automatic load(input logic [63:0] v, input string tag);
        step(4'd9, v[63:32], 32'h0, 2'd0, tag);
        step(4'd10, v[31:0], 32'h0, 2'd0, tag);
    endtask

    initial begin
        rst = 1'b1; op_i = 4'd0; src_a_i = '0; src_b_i = '0; shamt_i = '0;
        m_acc = 0; m_rd = '0;
        repeat (3) @(negedge clk);
        check(rd_data_o, 32'h0, "R1");
        rst = 1'b0;
        read_all("R1");

        load(64'h1234_5678_9ABC_DEF0, "R9");
        read_all("R9");
        step(4'd10, 32'h0BAD_F00D, 32'h0, 2'd0, "R9");
        read_all("R9");

        step(4'd0, 32'hDEAD_BEEF, 32'hCAFE_F00D, 2'd2, "R10");
        step(4'd15, 32'hDEAD_BEEF, 32'hCAFE_F00D, 2'd2, "R10");
        step(4'd11, 32'h1111_2222, 32'h3333_4444, 2'd1, "R10");
        read_all("R10");

        step(4'd1, 32'h7FFF_0001, 32'h8000_0002, 2'd0, "R2");
        read_all("R2");
        step(4'd1, 32'hFFFD_1234, 32'h0005_4321, 2'd0, "R2");
        read_all("R2");

        step(4'd2, 32'h1234_FFFF, 32'h5678_0003, 2'd0, "R3");
        read_all("R3");
        step(4'd2, 32'h0000_8000, 32'h0000_8000, 2'd0, "R3");
        read_all("R3");

        step(4'd3, 32'h0100_0000, 32'h0200_0000, 2'd0, "R4");
        step(4'd4, 32'h0000_FFFE, 32'h0000_0007, 2'd0, "R4");
        read_all("R4");
        load(64'h7FFF_FFFF_FFFF_0000, "R4");
        step(4'd4, 32'h0000_0001, 32'h0000_0001, 2'd0, "R4");
        read_all("R4");
        load(64'h0000_0000_FFFF_0000, "R4");
        step(4'd3, 32'h0001_0000, 32'h0001_0000, 2'd0, "R4");
        read_all("R4");

        load(64'h0000_1234_8000_0000, "R5");
        step(4'd5, 32'h0, 32'h0, 2'd1, "R5");
        read_all("R5");
        load(64'hFFFF_F000_4000_0000, "R5");
        step(4'd5, 32'h0, 32'h0, 2'd2, "R5");
        read_all("R5");
        load(64'h0000_0100_7FFF_FFFF, "R5");
        step(4'd5, 32'h0, 32'h0, 2'd0, "R5");
        read_all("R5");
        load(64'h0000_0100_3FFF_FFFF, "R5");
        step(4'd5, 32'h0, 32'h0, 2'd3, "R5");
        read_all("R5");

        load(64'h0000_3FFF_8000_0000, "R6");
        step(4'd5, 32'h0, 32'h0, 2'd1, "R6");
        read_all("R6");
        load(64'h0000_4000_0000_0000, "R6");
        step(4'd5, 32'h0, 32'h0, 2'd1, "R6");
        read_all("R6");
        load(64'h0000_3FFF_7FFF_FFFF, "R6");
        step(4'd5, 32'h0, 32'h0, 2'd1, "R6");
        read_all("R6");

        load(64'hFFFF_0000_0000_0000, "R7");
        step(4'd5, 32'h0, 32'h0, 2'd2, "R7");
        read_all("R7");
        load(64'hFFFF_C000_0000_0000, "R7");
        step(4'd5, 32'h0, 32'h0, 2'd1, "R7");
        read_all("R7");
        load(64'hFFFF_BFFF_0000_0000, "R7");
        step(4'd5, 32'h0, 32'h0, 2'd1, "R7");
        read_all("R7");

        step(4'd7, 32'h0, 32'h0, 2'd0, "R8");
        step(4'd1, 32'h1234_5678, 32'h9ABC_DEF0, 2'd0, "R8");
        step(4'd0, 32'h0, 32'h0, 2'd0, "R8");
        read_all("R8");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired before completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule